// File: doc/BRIEF.md
# Control-Request Register Bridge

This block sits behind a device's control endpoint and turns simplified vendor control requests into register traffic. Each request arrives as a one-cycle strobe carrying a request code, a 16-bit value word, a 16-bit index word and a transfer direction. The block serves one request at a time. Depending on the code, it performs an access on a local register port, an access on a sensor register port, or a local action. The local actions are a calibration start with a threshold, a reconfigure pulse, and a stored raw/processed mode bit.

Sensor writes are masked. The upper half of the value word selects which register bits change, and the lower half supplies their new values. The block first reads the sensor register, then merges the old and new bits, then writes the result back. If the mask is all zero, no write is issued and the request behaves as a read. Each request ends with a one-cycle completion strobe. That strobe carries either success or stall, and, for device-to-host transfers that succeed, one reply byte.

Both register ports use a plain request/acknowledge handshake. The request is held until the acknowledge arrives, and the acknowledge may come after any number of cycles.

Top module: `vreq_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, `raw_mode` is 0, and `loc_req`, `sen_req`, `done`, `cal_start` and `reconf` are all 0.
- R2: Code 0xA4 with `req_dir_in`=1 issues one read on the local port at address `req_index`. It completes with success and one reply byte equal to the acknowledged read data.
- R3: Code 0xA4 with `req_dir_in`=0 issues one write on the local port at address `req_index`, with data `req_value[7:0]`. It completes with success and no reply byte.
- R4: Code 0xA5 with `req_dir_in`=0 and a nonzero mask `req_value[15:8]` reads sensor register `req_index`, then writes (old AND NOT mask) OR (`req_value[7:0]` AND mask) back to it. Success is reported only after the write is acknowledged.
- R5: Code 0xA5 with `req_dir_in`=0 and a zero mask issues only the read, performs no sensor write, and completes with success and no reply byte.
- R6: Code 0xA5 with `req_dir_in`=1 issues one sensor read and returns the read data as the reply byte.
- R7: Code 0xA2 with `req_dir_in`=0 raises `cal_start` for exactly one cycle, with `cal_thresh` = `req_value[7:0]`. With `req_dir_in`=1, it stalls and does not raise `cal_start`.
- R8: Code 0xA3 with `req_dir_in`=0 raises `reconf` for exactly one cycle. With `req_dir_in`=1, it stalls and does not raise `reconf`.
- R9: Code 0xA7 with `req_dir_in`=0 sets `raw_mode` to `req_value[0]`. With `req_dir_in`=1, it returns a reply byte whose bit 0 is `raw_mode` and whose bits 7:1 are zero. `raw_mode` changes on no other request.
- R10: Code 0xA0 completes with stall in either direction and has no side effect.
- R11: Codes 0xA1, 0xA6, and any code outside 0xA0..0xA7 complete with stall. They cause no port access, no pulse and no mode change, and a stalled completion carries no reply byte.
- R12: `req_ready` drops in the cycle after a request is accepted and returns only after `done`. A strobe on `req_valid` while `req_ready` is 0 is ignored.
- R13: On both register ports, once a request is raised, the request, its address and its write enable stay unchanged until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_code | input | 8 | Vendor request code |
| req_value | input | VAL_W | Value word (mask in upper half for 0xA5) |
| req_index | input | IDX_W | Index word (register address) |
| req_dir_in | input | 1 | 1 = device-to-host (read), 0 = host-to-device (write) |
| done | output | 1 | One-cycle completion strobe |
| stall | output | 1 | With `done`: request rejected |
| reply_valid | output | 1 | With `done`: a reply byte is returned |
| reply_data | output | VAL_W/2 | Reply byte |
| loc_req | output | 1 | Local port request |
| loc_we | output | 1 | Local port write enable |
| loc_addr | output | LOC_AW | Local port address |
| loc_wdata | output | VAL_W/2 | Local port write data |
| loc_ack | input | 1 | Local port acknowledge |
| loc_rdata | input | VAL_W/2 | Local port read data, valid with `loc_ack` |
| sen_req | output | 1 | Sensor port request |
| sen_we | output | 1 | Sensor port write enable |
| sen_addr | output | SEN_AW | Sensor port address |
| sen_wdata | output | VAL_W/2 | Sensor port write data |
| sen_ack | input | 1 | Sensor port acknowledge |
| sen_rdata | input | VAL_W/2 | Sensor port read data, valid with `sen_ack` |
| cal_start | output | 1 | One-cycle calibration start |
| cal_thresh | output | VAL_W/2 | Calibration threshold |
| reconf | output | 1 | One-cycle reconfigure pulse |
| raw_mode | output | 1 | 1 = raw, 0 = processed video |

## Verification
The hardest case to reach is a new request strobe arriving while a masked sensor write is still in progress. Such a strobe must leave no trace, even though it targets a function with a visible pulse. To get there, the bench stretches the sensor acknowledge latency so that the read-merge-write sequence spans many cycles. While it is running, the bench holds a reconfigure request on the input for several cycles. It then checks three things: that no reconfigure pulse appeared, that the merged register value is right, and that exactly one completion was produced. A long local-port latency separately stresses holding the request until the acknowledge.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
   typedef enum logic [2:0] {
      OP_STALL, OP_LOC, OP_SEN, OP_CAL, OP_RECONF, OP_MODE
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOC, ST_SRD, ST_SWR, ST_FIN
   } st_e;

   localparam logic [7:0] CODE_BOOT   = 8'hA0;
   localparam logic [7:0] CODE_CAL    = 8'hA2;
   localparam logic [7:0] CODE_RECONF = 8'hA3;
   localparam logic [7:0] CODE_LOC    = 8'hA4;
   localparam logic [7:0] CODE_SEN    = 8'hA5;
   localparam logic [7:0] CODE_MODE   = 8'hA7;
endpackage

// File: rtl/vreq_decode.sv
module vreq_decode
   import vreq_pkg::*;
(
   input  logic [7:0] code,
   input  logic       dir_in,
   output op_e        op
);
   always_comb begin
      unique case (code)
         CODE_CAL:    op = dir_in ? OP_STALL : OP_CAL;
         CODE_RECONF: op = dir_in ? OP_STALL : OP_RECONF;
         CODE_LOC:    op = OP_LOC;
         CODE_SEN:    op = OP_SEN;
         CODE_MODE:   op = OP_MODE;
         default:     op = OP_STALL;   // boot query, reserved, unknown
      endcase
   end
endmodule

// File: rtl/vreq_merge.sv
module vreq_merge #(
   parameter int W = 8
) (
   input  logic [W-1:0] old_val,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] new_val,
   output logic [W-1:0] merged
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign merged[b] = mask[b] ? new_val[b] : old_val[b];
   end
endmodule

// File: rtl/vreq_bridge.sv
module vreq_bridge
   import vreq_pkg::*;
#(
   parameter int VAL_W  = 16,
   parameter int IDX_W  = 16,
   parameter int LOC_AW = 16,
   parameter int SEN_AW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [7:0]          req_code,
   input  logic [VAL_W-1:0]    req_value,
   input  logic [IDX_W-1:0]    req_index,
   input  logic                req_dir_in,
   output logic                done,
   output logic                stall,
   output logic                reply_valid,
   output logic [VAL_W/2-1:0]  reply_data,
   output logic                loc_req,
   output logic                loc_we,
   output logic [LOC_AW-1:0]   loc_addr,
   output logic [VAL_W/2-1:0]  loc_wdata,
   input  logic                loc_ack,
   input  logic [VAL_W/2-1:0]  loc_rdata,
   output logic                sen_req,
   output logic                sen_we,
   output logic [SEN_AW-1:0]   sen_addr,
   output logic [VAL_W/2-1:0]  sen_wdata,
   input  logic                sen_ack,
   input  logic [VAL_W/2-1:0]  sen_rdata,
   output logic                cal_start,
   output logic [VAL_W/2-1:0]  cal_thresh,
   output logic                reconf,
   output logic                raw_mode
);
   localparam int DW = VAL_W / 2;

   if (VAL_W < 2 || (VAL_W % 2) != 0) begin : g_bad_val
      $error("VAL_W must be even and at least 2");
   end
   if (LOC_AW > IDX_W || SEN_AW > IDX_W) begin : g_bad_aw
      $error("port address widths cannot exceed IDX_W");
   end

   st_e               st;
   op_e               op_d;
   logic              dir_q;
   logic [VAL_W-1:0]  val_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DW-1:0]     wr_q;
   logic [DW-1:0]     merged;
   logic              rsp_stall, rsp_rv;
   logic [DW-1:0]     rsp_data;
   logic              raw_q, cal_q, rcf_q;
   logic [DW-1:0]     cal_th_q;
   logic [DW-1:0]     mask_q;

   assign mask_q = val_q[VAL_W-1:DW];

   vreq_decode u_dec (
      .code   (req_code),
      .dir_in (req_dir_in),
      .op     (op_d)
   );

   vreq_merge #(.W(DW)) u_merge (
      .old_val (sen_rdata),
      .mask    (mask_q),
      .new_val (val_q[DW-1:0]),
      .merged  (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         dir_q     <= 1'b0;
         val_q     <= '0;
         idx_q     <= '0;
         wr_q      <= '0;
         rsp_stall <= 1'b0;
         rsp_rv    <= 1'b0;
         rsp_data  <= '0;
         raw_q     <= 1'b0;
         cal_q     <= 1'b0;
         rcf_q     <= 1'b0;
         cal_th_q  <= '0;
      end else begin
         cal_q <= 1'b0;
         rcf_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               dir_q     <= req_dir_in;
               val_q     <= req_value;
               idx_q     <= req_index;
               rsp_stall <= 1'b0;
               rsp_rv    <= 1'b0;
               rsp_data  <= '0;
               unique case (op_d)
                  OP_LOC: st <= ST_LOC;
                  OP_SEN: st <= ST_SRD;
                  OP_CAL: begin
                     cal_q    <= 1'b1;
                     cal_th_q <= req_value[DW-1:0];
                     st       <= ST_FIN;
                  end
                  OP_RECONF: begin
                     rcf_q <= 1'b1;
                     st    <= ST_FIN;
                  end
                  OP_MODE: begin
                     if (req_dir_in) begin
                        rsp_rv   <= 1'b1;
                        rsp_data <= {{(DW-1){1'b0}}, raw_q};
                     end else begin
                        raw_q <= req_value[0];
                     end
                     st <= ST_FIN;
                  end
                  default: begin
                     rsp_stall <= 1'b1;
                     st        <= ST_FIN;
                  end
               endcase
            end
            ST_LOC: if (loc_ack) begin
               rsp_rv   <= dir_q;
               rsp_data <= dir_q ? loc_rdata : '0;
               st       <= ST_FIN;
            end
            ST_SRD: if (sen_ack) begin
               if (dir_q) begin
                  rsp_rv   <= 1'b1;
                  rsp_data <= sen_rdata;
                  st       <= ST_FIN;
               end else if (mask_q == '0) begin
                  st <= ST_FIN;
               end else begin
                  wr_q <= merged;
                  st   <= ST_SWR;
               end
            end
            ST_SWR: if (sen_ack) st <= ST_FIN;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (st == ST_IDLE);
   assign done        = (st == ST_FIN);
   assign stall       = rsp_stall;
   assign reply_valid = rsp_rv;
   assign reply_data  = rsp_data;
   assign loc_req     = (st == ST_LOC);
   assign loc_we      = ~dir_q;
   assign loc_addr    = idx_q[LOC_AW-1:0];
   assign loc_wdata   = val_q[DW-1:0];
   assign sen_req     = (st == ST_SRD) || (st == ST_SWR);
   assign sen_we      = (st == ST_SWR);
   assign sen_addr    = idx_q[SEN_AW-1:0];
   assign sen_wdata   = wr_q;
   assign cal_start   = cal_q;
   assign cal_thresh  = cal_th_q;
   assign reconf      = rcf_q;
   assign raw_mode    = raw_q;
endmodule

// File: rtl/vreq_bridge_chk.sv
module vreq_bridge_chk #(
   parameter int LOC_AW = 16,
   parameter int SEN_AW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [7:0]        req_code,
   input logic              req_dir_in,
   input logic              done,
   input logic              stall,
   input logic              reply_valid,
   input logic              loc_req,
   input logic              loc_we,
   input logic [LOC_AW-1:0] loc_addr,
   input logic              loc_ack,
   input logic              sen_req,
   input logic              sen_we,
   input logic [SEN_AW-1:0] sen_addr,
   input logic              sen_ack,
   input logic              cal_start,
   input logic              reconf,
   input logic              raw_mode
);
   p_busy_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_ready_needs_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !done) |=> !req_ready);

   p_cal_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);

   p_reconf_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |=> !reconf);

   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready && req_code == 8'hA7 && !req_dir_in) |=> $stable(raw_mode));

   p_stall_no_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && stall) |-> !reply_valid);

   p_loc_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && !loc_ack) |=> (loc_req && $stable(loc_we) && $stable(loc_addr)));

   p_sen_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (sen_req && !sen_ack) |=> (sen_req && $stable(sen_we) && $stable(sen_addr)));

   p_one_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_req && sen_req));
endmodule

bind vreq_bridge vreq_bridge_chk #(.LOC_AW(LOC_AW), .SEN_AW(SEN_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_code(req_code), .req_dir_in(req_dir_in), .done(done), .stall(stall),
   .reply_valid(reply_valid), .loc_req(loc_req), .loc_we(loc_we),
   .loc_addr(loc_addr), .loc_ack(loc_ack), .sen_req(sen_req), .sen_we(sen_we),
   .sen_addr(sen_addr), .sen_ack(sen_ack), .cal_start(cal_start),
   .reconf(reconf), .raw_mode(raw_mode)
);

// File: tb/sim_vreq_bridge.sv
module sim_vreq_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_code = 8'h00;
   logic [15:0] req_value = 16'h0;
   logic [15:0] req_index = 16'h0;
   logic        req_dir_in = 1'b0;
   logic        done, stall, reply_valid;
   logic [7:0]  reply_data;
   logic        loc_req, loc_we, loc_ack;
   logic [15:0] loc_addr;
   logic [7:0]  loc_wdata, loc_rdata;
   logic        sen_req, sen_we, sen_ack;
   logic [15:0] sen_addr;
   logic [7:0]  sen_wdata, sen_rdata;
   logic        cal_start, reconf, raw_mode;
   logic [7:0]  cal_thresh;

   always #2.5 clk = ~clk;   // 200 MHz

   vreq_bridge u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_code(req_code), .req_value(req_value), .req_index(req_index),
      .req_dir_in(req_dir_in), .done(done), .stall(stall),
      .reply_valid(reply_valid), .reply_data(reply_data),
      .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
      .sen_req(sen_req), .sen_we(sen_we), .sen_addr(sen_addr),
      .sen_wdata(sen_wdata), .sen_ack(sen_ack), .sen_rdata(sen_rdata),
      .cal_start(cal_start), .cal_thresh(cal_thresh), .reconf(reconf),
      .raw_mode(raw_mode)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- bus responders ----------------
   logic [7:0] lmem [0:255];
   logic [7:0] smem [0:15];
   int loc_lat = 1, sen_lat = 1;
   int lcnt = 0, scnt = 0;
   int loc_acc = 0, sen_rd = 0, sen_wr = 0;

   initial begin
      loc_ack = 1'b0; sen_ack = 1'b0; loc_rdata = 8'h0; sen_rdata = 8'h0;
      for (int i = 0; i < 256; i++) lmem[i] = 8'h00;
      for (int i = 0; i < 16; i++) smem[i] = 8'h00;
   end

   always @(posedge clk) begin
      loc_ack <= 1'b0;
      if (loc_req && !loc_ack) begin
         if (lcnt >= loc_lat) begin
            lcnt    <= 0;
            loc_ack <= 1'b1;
            loc_acc <= loc_acc + 1;
            if (loc_we) lmem[loc_addr[7:0]] <= loc_wdata;
            else        loc_rdata <= lmem[loc_addr[7:0]];
         end else lcnt <= lcnt + 1;
      end
   end

   always @(posedge clk) begin
      sen_ack <= 1'b0;
      if (sen_req && !sen_ack) begin
         if (scnt >= sen_lat) begin
            scnt    <= 0;
            sen_ack <= 1'b1;
            if (sen_we) begin
               smem[sen_addr[3:0]] <= sen_wdata;
               sen_wr <= sen_wr + 1;
            end else begin
               sen_rdata <= smem[sen_addr[3:0]];
               sen_rd <= sen_rd + 1;
            end
         end else scnt <= scnt + 1;
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic       st;
      logic       rv;
      logic [7:0] d;
      string      tag;
   } exp_t;
   exp_t q[$];
   exp_t e;
   int cal_cnt = 0, rcf_cnt = 0, done_cnt = 0;
   logic [7:0] cal_seen = 8'h0;
   bit cal_prev = 0, rcf_prev = 0, wide = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            done_cnt++;
            if (q.size() == 0) begin
               check(0, "R12", "completion without request", 1, 0);
            end else begin
               e = q.pop_front();
               check(stall == e.st && reply_valid == e.rv && (!e.rv || reply_data == e.d),
                     e.tag, "status/reply {stall,rv,data}",
                     {stall, reply_valid, reply_data}, {e.st, e.rv, e.d});
            end
         end
         if (cal_start) begin cal_cnt++; cal_seen = cal_thresh; end
         if (reconf) rcf_cnt++;
         if ((cal_start && cal_prev) || (reconf && rcf_prev)) wide = 1;
         cal_prev = cal_start;
         rcf_prev = reconf;
      end
   end

   task automatic issue(input [7:0] c, input [15:0] v, input [15:0] ix,
                        input logic din, input logic es, input logic erv,
                        input [7:0] ed, input string tag);
      exp_t x;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_code = c; req_value = v; req_index = ix; req_dir_in = din;
      req_valid = 1'b1;
      x.st = es; x.rv = erv; x.d = ed; x.tag = tag;
      q.push_back(x);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!req_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(input [7:0] c, input [15:0] v, input [15:0] ix,
                      input logic din, input logic es, input logic erv,
                      input [7:0] ed, input string tag);
      issue(c, v, ix, din, es, erv, ed, tag);
      wait_idle();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog run hung actual=0x0 expected=0x1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int la, sw, sr, cc, rc;
      smem[3] = 8'hA5;
      smem[4] = 8'h0F;
      smem[7] = 8'h3C;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(req_ready && !raw_mode && !loc_req && !sen_req && !done && !cal_start && !reconf,
            "R1", "reset outputs", {req_ready, raw_mode, loc_req, sen_req, done}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 local write
      run(8'hA4, 16'hAB55, 16'h0012, 1'b0, 0, 0, 8'h00, "R3");
      check(lmem[8'h12] == 8'h55, "R3", "local write data", lmem[8'h12], 8'h55);
      // R2 local read, short and long latency
      run(8'hA4, 16'h0000, 16'h0012, 1'b1, 0, 1, 8'h55, "R2");
      loc_lat = 7;
      lmem[8'h40] = 8'h9E;
      run(8'hA4, 16'h0000, 16'h0040, 1'b1, 0, 1, 8'h9E, "R2 long latency R13");
      loc_lat = 0;

      // R6 sensor read
      run(8'hA5, 16'h0000, 16'h0003, 1'b1, 0, 1, 8'hA5, "R6");
      // R4 masked write: (A5 & F0) | (3C & 0F) = AC
      sw = sen_wr;
      run(8'hA5, 16'h0F3C, 16'h0003, 1'b0, 0, 0, 8'h00, "R4");
      check(smem[3] == 8'hAC, "R4", "merged value", smem[3], 8'hAC);
      check(sen_wr == sw + 1, "R4", "sensor write count", sen_wr - sw, 1);
      // R4 full mask
      run(8'hA5, 16'hFF00, 16'h0003, 1'b0, 0, 0, 8'h00, "R4");
      check(smem[3] == 8'h00, "R4", "full mask value", smem[3], 8'h00);
      // R5 zero mask
      sw = sen_wr; sr = sen_rd;
      run(8'hA5, 16'h00FF, 16'h0007, 1'b0, 0, 0, 8'h00, "R5");
      check(sen_wr == sw && sen_rd == sr + 1 && smem[7] == 8'h3C, "R5",
            "zero mask writes", {sen_wr - sw, smem[7]}, {32'd0, 8'h3C});

      // R7 calibration
      cc = cal_cnt;
      run(8'hA2, 16'h00C8, 16'h0000, 1'b0, 0, 0, 8'h00, "R7");
      check(cal_cnt == cc + 1 && cal_seen == 8'hC8, "R7", "cal pulse/threshold",
            cal_seen, 8'hC8);
      run(8'hA2, 16'h0011, 16'h0000, 1'b1, 1, 0, 8'h00, "R7 read stalls");
      check(cal_cnt == cc + 1, "R7", "cal pulse on read", cal_cnt - cc, 1);

      // R8 reconfigure
      rc = rcf_cnt;
      run(8'hA3, 16'h1234, 16'h0000, 1'b0, 0, 0, 8'h00, "R8");
      run(8'hA3, 16'h0000, 16'h0000, 1'b1, 1, 0, 8'h00, "R8 read stalls");
      check(rcf_cnt == rc + 1, "R8", "reconf pulses", rcf_cnt - rc, 1);
      check(!wide, "R8", "pulse width over one cycle", wide, 0);

      // R9 mode bit
      run(8'hA7, 16'h0001, 16'h0000, 1'b0, 0, 0, 8'h00, "R9");
      check(raw_mode == 1'b1, "R9", "raw mode set", raw_mode, 1);
      run(8'hA7, 16'h0000, 16'h0000, 1'b1, 0, 1, 8'h01, "R9 read back");
      run(8'hA7, 16'h00FE, 16'h0000, 1'b0, 0, 0, 8'h00, "R9");
      check(raw_mode == 1'b0, "R9", "raw mode cleared", raw_mode, 0);
      run(8'hA7, 16'h0001, 16'h0000, 1'b0, 0, 0, 8'h00, "R9");

      // R10 / R11 stalls without side effects
      la = loc_acc; sw = sen_wr; sr = sen_rd; cc = cal_cnt; rc = rcf_cnt;
      run(8'hA0, 16'h0000, 16'h0000, 1'b1, 1, 0, 8'h00, "R10");
      run(8'hA0, 16'h00FF, 16'h0000, 1'b0, 1, 0, 8'h00, "R10");
      run(8'hA1, 16'h00FF, 16'h0000, 1'b0, 1, 0, 8'h00, "R11");
      run(8'hA6, 16'hFFFF, 16'h0003, 1'b0, 1, 0, 8'h00, "R11");
      run(8'h42, 16'h0000, 16'h0003, 1'b1, 1, 0, 8'h00, "R11");
      run(8'hA8, 16'h0000, 16'h0012, 1'b0, 1, 0, 8'h00, "R11");
      check(loc_acc == la && sen_wr == sw && sen_rd == sr && cal_cnt == cc &&
            rcf_cnt == rc && raw_mode == 1'b1, "R11", "side effects of stalled codes",
            (loc_acc - la) + (sen_wr - sw) + (sen_rd - sr) + (cal_cnt - cc) + (rcf_cnt - rc), 0);

      // R12 strobe while busy is ignored: (0F & 0F) | (5A & F0) = 5F
      sen_lat = 5;
      rc = rcf_cnt;
      issue(8'hA5, 16'hF05A, 16'h0004, 1'b0, 0, 0, 8'h00, "R12 busy");
      check(!req_ready, "R12", "ready after accept", req_ready, 0);
      @(negedge clk);
      req_code = 8'hA3; req_dir_in = 1'b0; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      check(rcf_cnt == rc, "R12", "ignored strobe pulses", rcf_cnt - rc, 0);
      check(smem[4] == 8'h5F, "R12", "busy merge value", smem[4], 8'h5F);
      check(q.size() == 0, "R12", "pending completions", q.size(), 0);
      sen_lat = 1;

      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule